// File: doc/BRIEF.md
# Accumulator and Link Arithmetic Unit

This block holds an 18-bit accumulator and a separate 1-bit link register. Each cycle where the request strobe is high, it runs one operation picked by a 4-bit code. The operations are:

- clearing or inverting either register;
- rotating the 19-bit chain formed by link and accumulator;
- adding a memory operand in two's-complement or one's-complement form;
- combining the accumulator with the memory operand by AND or XOR;
- merging a data-switch word into the accumulator by inclusive OR.

The link has a different role in each kind of operation. In two's-complement addition it takes the carry out of the top bit, acting as a 19th bit. In one's-complement addition it becomes a sticky overflow flag. In rotates it is one stage of the loop. A sense output reports the link state on its own, apart from the accumulator.

The operand and switch word arrive directly on ports. Each request takes effect at the next clock edge.

Top module: `acc_link_unit`

## Requirements
- R1: After reset (rst_ni low) acc_o is 0 and link_o is 0.
- R2: While valid_i is low, acc_o and link_o keep their values whatever op_i, mem_i and sw_i carry.
- R3: Code 0 clears the accumulator and code 1 inverts every accumulator bit; the link is unchanged by both.
- R4: Code 2 clears the link and code 3 inverts the link; the accumulator is unchanged by both.
- R5: Code 4 rotates {link, acc} left by one: the new link is old acc[17], and the new acc is {old acc[16:0], old link}.
- R6: Code 5 rotates {link, acc} right by one: the new link is old acc[0], and the new acc is {old link, old acc[17:1]}.
- R7: Code 6 sets acc to (acc + mem_i) mod 2^18 and sets the link to the carry out of bit 17.
- R8: Code 7 adds in one's complement with end-around carry (sum + carry out). If both operands have equal bit 17 and the result's bit 17 differs, the link is set to 1; otherwise the link is unchanged.
- R9: Code 8 sets acc to acc AND mem_i, and code 9 sets acc to acc XOR mem_i; the link is unchanged.
- R10: Code 10 sets acc to acc OR sw_i, and mem_i has no effect; the link is unchanged.
- R11: Codes 11 to 15 change neither acc nor link.
- R12: link_sense_o equals link_o at all times, independent of the accumulator value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe; one operation per high cycle |
| op_i | input | 4 | Operation code |
| mem_i | input | 18 | Memory operand |
| sw_i | input | 18 | Data-switch word |
| acc_o | output | 18 | Accumulator |
| link_o | output | 1 | Link register |
| link_sense_o | output | 1 | Link-sense flag |

## Verification
The bench builds the block with its default DATA_W of 18, so the carry and sign positions are at bit 17, as the requirements state. At this width, all-ones operands can reach the one's-complement end-around carry, the negative-zero result and both signs of overflow. Nineteen successive rotates bring a pattern back to its start, which shows the loop is 19 bits long.

// File: rtl/acl_pkg.sv
package acl_pkg;
  typedef enum logic [3:0] {
    OP_CLR_AC = 4'd0,
    OP_CMP_AC = 4'd1,
    OP_CLR_LK = 4'd2,
    OP_CMP_LK = 4'd3,
    OP_ROT_L  = 4'd4,
    OP_ROT_R  = 4'd5,
    OP_ADD2   = 4'd6,
    OP_ADD1   = 4'd7,
    OP_AND    = 4'd8,
    OP_XOR    = 4'd9,
    OP_OR_SW  = 4'd10
  } op_e;
endpackage

// File: rtl/acl_adder.sv
module acl_adder #(
  parameter int DATA_W = 18
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum2_o,
  output logic              carry2_o,
  output logic [DATA_W-1:0] sum1_o,
  output logic              ovf1_o
);
  localparam int MSB = DATA_W - 1;
  logic [DATA_W:0] raw;

  always_comb begin
    raw      = {1'b0, a_i} + {1'b0, b_i};
    sum2_o   = raw[MSB:0];
    carry2_o = raw[DATA_W];
    // end-around carry cannot overflow again: raw top set implies low part <= 2^W-2
    sum1_o   = raw[MSB:0] + {{MSB{1'b0}}, raw[DATA_W]};
    ovf1_o   = (a_i[MSB] == b_i[MSB]) && (sum1_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/acl_rotlogic.sv
module acl_rotlogic #(
  parameter int DATA_W = 18
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W:0]   rol_o,
  output logic [DATA_W:0]   ror_o,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] xor_o,
  output logic [DATA_W-1:0] or_o
);
  localparam int MSB = DATA_W - 1;

  // {link, acc} as one 19-bit loop
  assign rol_o = {acc_i[MSB], acc_i[MSB-1:0], link_i};
  assign ror_o = {acc_i[0], link_i, acc_i[MSB:1]};
  assign and_o = acc_i & mem_i;
  assign xor_o = acc_i ^ mem_i;
  assign or_o  = acc_i | sw_i;
endmodule

// File: rtl/acc_link_unit.sv
module acc_link_unit
  import acl_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              link_o,
  output logic              link_sense_o
);
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              link_q, link_d;
  logic [DATA_W-1:0] sum2, sum1, and_w, xor_w, or_w;
  logic              carry2, ovf1;
  logic [DATA_W:0]   rol_w, ror_w;

  acl_adder #(.DATA_W(DATA_W)) u_adder (
    .a_i(acc_q), .b_i(mem_i),
    .sum2_o(sum2), .carry2_o(carry2), .sum1_o(sum1), .ovf1_o(ovf1)
  );

  acl_rotlogic #(.DATA_W(DATA_W)) u_rotlogic (
    .acc_i(acc_q), .link_i(link_q), .mem_i(mem_i), .sw_i(sw_i),
    .rol_o(rol_w), .ror_o(ror_w), .and_o(and_w), .xor_o(xor_w), .or_o(or_w)
  );

  always_comb begin
    acc_d  = acc_q;
    link_d = link_q;
    if (valid_i) begin
      case (op_e'(op_i))
        OP_CLR_AC: acc_d = '0;
        OP_CMP_AC: acc_d = ~acc_q;
        OP_CLR_LK: link_d = 1'b0;
        OP_CMP_LK: link_d = ~link_q;
        OP_ROT_L:  {link_d, acc_d} = rol_w;
        OP_ROT_R:  {link_d, acc_d} = ror_w;
        OP_ADD2:   {link_d, acc_d} = {carry2, sum2};
        OP_ADD1: begin
          acc_d  = sum1;
          link_d = link_q | ovf1;
        end
        OP_AND:    acc_d = and_w;
        OP_XOR:    acc_d = xor_w;
        OP_OR_SW:  acc_d = or_w;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      link_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      link_q <= link_d;
    end
  end

  assign acc_o        = acc_q;
  assign link_o       = link_q;
  assign link_sense_o = link_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_q) && $stable(link_q));

  // R3
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd0 |=> acc_q == '0 && link_q == $past(link_q));

  // R4
  link_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd3 |=> link_q != $past(link_q) && $stable(acc_q));

  // R5
  rot_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd4 |=> $countones({link_q, acc_q}) == $past($countones({link_q, acc_q})));

  // R6
  rot_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd5 |=> link_q == $past(acc_q[0]));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd7 && link_q |=> link_q);

  // R9
  logic_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 4'd8 || op_i == 4'd9 || op_i == 4'd10) |=> $stable(link_q));

  // R11
  unused_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i > 4'd10 |=> $stable(acc_q) && $stable(link_q));

  // R12
  sense_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_sense_o == link_o);
endmodule

// File: tb/acc_link_unit_bench.sv
module acc_link_unit_bench;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] mem = '0;
  logic [W-1:0] sw = '0;
  logic [W-1:0] acc;
  logic         link, sense;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] e_acc;
  logic         e_lk;

  always #4 clk = ~clk;

  acc_link_unit #(.DATA_W(W)) u_acc_link_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .mem_i(mem), .sw_i(sw), .acc_o(acc), .link_o(link), .link_sense_o(sense)
  );

  task automatic check(input string req);
    checks++;
    if (acc !== e_acc || link !== e_lk) begin
      errors++;
      $display("FAIL %s: acc=%h link=%b expected acc=%h link=%b", req, acc, link, e_acc, e_lk);
    end
    checks++;
    if (sense !== link) begin
      errors++;
      $display("FAIL R12 (%s): sense=%b expected %b", req, sense, link);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [W-1:0] m, input logic [W-1:0] s);
    @(negedge clk);
    op = o; mem = m; sw = s; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; op = 4'd15; mem = ~m; sw = ~s;
  endtask

  task automatic load(input logic [W-1:0] v, input logic l);
    run(4'd0, '0, '0);
    run(4'd10, '0, v);
    run(4'd2, '0, '0);
    if (l) run(4'd3, '0, '0);
    e_acc = v; e_lk = l;
    check("setup");
  endtask

  task automatic t_reset();
    e_acc = '0; e_lk = 1'b0;
    check("R1");
  endtask

  task automatic t_idle();
    load(18'h15A5A, 1'b1);
    @(negedge clk);
    op = 4'd1; mem = ONES; sw = ONES; valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2");
  endtask

  task automatic t_acc_ops();
    load(18'h0F0F0, 1'b1);
    run(4'd1, ONES, ONES); e_acc = 18'h30F0F; check("R3 complement");
    run(4'd0, ONES, ONES); e_acc = '0; check("R3 clear");
  endtask

  task automatic t_link_ops();
    load(18'h12345, 1'b0);
    run(4'd3, '0, '0); e_lk = 1'b1; check("R4 complement");
    run(4'd3, '0, '0); e_lk = 1'b0; check("R4 complement back");
    run(4'd3, '0, '0); run(4'd2, ONES, ONES); e_lk = 1'b0; check("R4 clear");
  endtask

  task automatic t_rotates();
    load(18'h20001, 1'b0);
    run(4'd4, '0, '0); e_acc = 18'h00002; e_lk = 1'b1; check("R5 msb to link");
    run(4'd4, '0, '0); e_acc = 18'h00005; e_lk = 1'b0; check("R5 link to lsb");
    run(4'd5, '0, '0); e_acc = 18'h00002; e_lk = 1'b1; check("R6 lsb to link");
    run(4'd5, '0, '0); e_acc = 18'h20001; e_lk = 1'b0; check("R6 link to msb");
    load(18'h0C3A1, 1'b1);
    for (int i = 0; i < 19; i++) run(4'd4, '0, '0);
    check("R5 19-step loop");
    for (int i = 0; i < 19; i++) run(4'd5, '0, '0);
    check("R6 19-step loop");
  endtask

  task automatic t_add2();
    load(18'h3FFFF, 1'b0);
    run(4'd6, 18'h00001, '0); e_acc = '0; e_lk = 1'b1; check("R7 carry out");
    load(18'h01234, 1'b1);
    run(4'd6, 18'h00111, '0); e_acc = 18'h01345; e_lk = 1'b0; check("R7 no carry clears link");
  endtask

  task automatic t_add1();
    load(18'h00005, 1'b0);
    run(4'd7, 18'h3FFFD, '0); e_acc = 18'h00003; e_lk = 1'b0; check("R8 end-around");
    load(18'h3FFFE, 1'b0);
    run(4'd7, 18'h00001, '0); e_acc = 18'h3FFFF; e_lk = 1'b0; check("R8 negative zero");
    load(18'h1FFFF, 1'b0);
    run(4'd7, 18'h00001, '0); e_acc = 18'h20000; e_lk = 1'b1; check("R8 positive overflow");
    load(18'h20000, 1'b0);
    run(4'd7, 18'h20000, '0); e_acc = 18'h00001; e_lk = 1'b1; check("R8 negative overflow");
    load(18'h00010, 1'b1);
    run(4'd7, 18'h00020, '0); e_acc = 18'h00030; e_lk = 1'b1; check("R8 link kept");
  endtask

  task automatic t_logic();
    load(18'h3C3C3, 1'b1);
    run(4'd8, 18'h0FF0F, ONES); e_acc = 18'h0C303; check("R9 and");
    run(4'd9, 18'h3FFFF, '0); e_acc = 18'h33CFC; check("R9 xor");
    load(18'h00F00, 1'b0);
    run(4'd10, ONES, 18'h2000F); e_acc = 18'h20F0F; check("R10 or with switches");
  endtask

  task automatic t_unused();
    load(18'h2AAAA, 1'b1);
    for (int c = 11; c < 16; c++) run(c[3:0], ONES, ONES);
    check("R11");
    run(4'd0, '0, '0); e_acc = '0; check("R12 link with acc zero");
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_acc_ops();
    t_link_ops();
    t_rotates();
    t_add2();
    t_add1();
    t_logic();
    t_unused();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule